// File: doc/BRIEF.md
# Exception Entry Stack Frame Builder

This sequential unit carries out the memory side of taking an exception on a processor core. A single `start` pulse hands it the exception index, a flag that marks a hardware interrupt, and the pending interrupt level. It also receives the program counter, status word, active stack pointer, interrupt stack pointer and vector base. The unit then writes a formatted frame onto the stack through a word/long write port. After the frame it reads the handler address from the vector table. When that read completes it reports the new status word, the new program counter and the final stack pointer.

The frame layout depends on the class of the exception. Address errors and a group of instruction-caused faults get a frame with one extra long word. A hardware interrupt that arrives while the master bit of the status word is set gets two frames: a normal frame on the current stack, then a throwaway frame on the interrupt stack. All other exceptions get the short frame. Every memory access uses a req/ack handshake, so the unit works with a memory of any latency.

Top module: `exc_frame_builder`

## Requirements
- R1: Status word bits are: trace field 15:14, supervisor 13, master 12, interrupt mask 10:8. The new status word is the old one with bit 13 set and bits 15:14 cleared. For a hardware interrupt, bits 10:8 are replaced by the pending level. Every other bit is kept.
- R2: Bit 0 of the start stack pointer is cleared before the first push. Each push first lowers the stack pointer by its size (2 for a word, 4 for a long) and then writes at the lowered address.
- R3: A frame is pushed in this order: the optional extra long, then the word (format << 12) + 4 × index, then the return address as a long, then the stacked status as a word. Word data sits in bits 15:0 of `mem_wdata`, and bits 31:16 are zero.
- R4: Index 3 (address error) gets format 2 with an extra long of 0. Indices 4, 5, 6, 7 and 9 get format 2 with the current PC as the extra long.
- R5: All other exceptions get a format 0 frame with no extra long.
- R6: Two frames are pushed when `is_hw` is set, old status bit 12 is set and the index is 24 to 31. The first is a format 0 frame on the current stack that stacks the old status. The stack pointer then becomes `int_sp` with bit 0 cleared. The second is a format 1 frame that stacks the new status word, with bit 12 still set. The reported status word has bit 12 cleared, and `msp_out` gives the current-stack pointer after the first frame.
- R7: When `is_hw` is 0 and the index is 32 to 47, the stacked return address is PC + 2. In all other cases it is the PC.
- R8: After the last push the unit makes one long read at `vbr` + 4 × index. The read data appears on `new_pc`, and the final stack pointer appears on `new_sp`. For a single frame, `msp_out` equals `new_sp`.
- R9: A request holds its address, data, direction and size until `mem_ack` is seen. Each ack completes exactly one access.
- R10: `done` is high for exactly one cycle, the cycle after the read ack. The results hold until the next start. A `start` pulse while the unit is busy is ignored. After reset `done` and `mem_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin exception entry (taken only when idle) |
| exc_idx | input | 8 | Exception vector index |
| is_hw | input | 1 | Exception is a hardware interrupt |
| pend_lvl | input | 3 | Pending interrupt level |
| cur_pc | input | 32 | Current program counter |
| cur_sr | input | 16 | Current status word |
| cur_sp | input | 32 | Active stack pointer |
| int_sp | input | 32 | Interrupt stack pointer |
| vbr | input | 32 | Vector table base |
| mem_req | output | 1 | Memory access request |
| mem_wr | output | 1 | 1 = write, 0 = read |
| mem_long | output | 1 | 1 = long (4 bytes), 0 = word (2 bytes) |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data, word data in bits 15:0 |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data |
| done | output | 1 | One-cycle completion pulse |
| new_sr | output | 16 | New status word |
| new_pc | output | 32 | Handler address read from the vector table |
| new_sp | output | 32 | Final stack pointer |
| msp_out | output | 32 | Current-stack pointer after the first frame |

## Verification
The first push request is presented in the cycle after the clock edge that samples `start`. Every later access follows in the cycle after the ack of the access before it. `done` and the result ports change in the cycle after the vector read is acked. The bench's memory responder logs each access at the falling edge on which it raises ack, and waits zero to two cycles at random before each ack. The main sequence also samples only at falling edges: it waits for `done`, then compares the logged accesses and the result ports with a model built from the requirements. It checks that `done` is low again one falling edge later.

// File: rtl/efb_pkg.sv
package efb_pkg;
  localparam int ADDR_W = 32;
  localparam int SR_W   = 16;
  localparam int IDX_W  = 8;
  localparam int LVL_W  = 3;
  localparam int FMT_W  = 4;

  // status word fields
  localparam int SR_TR_HI = 15;
  localparam int SR_TR_LO = 14;
  localparam int SR_SUP   = 13;
  localparam int SR_MST   = 12;
  localparam int SR_IM_HI = 10;
  localparam int SR_IM_LO = 8;

  // exception indices the classifier decodes
  localparam logic [IDX_W-1:0] IX_ADDR_ERR = 8'd3;
  localparam logic [IDX_W-1:0] IX_ILLEGAL  = 8'd4;
  localparam logic [IDX_W-1:0] IX_DIVZ     = 8'd5;
  localparam logic [IDX_W-1:0] IX_BOUNDS   = 8'd6;
  localparam logic [IDX_W-1:0] IX_CONDTRAP = 8'd7;
  localparam logic [IDX_W-1:0] IX_TRACE    = 8'd9;
  localparam logic [IDX_W-1:0] IX_HW_LO    = 8'd24;
  localparam logic [IDX_W-1:0] IX_HW_HI    = 8'd31;
  localparam logic [IDX_W-1:0] IX_SWT_LO   = 8'd32;
  localparam logic [IDX_W-1:0] IX_SWT_HI   = 8'd47;

  // push steps within one frame
  localparam logic [1:0] STEP_EXTRA = 2'd0;
  localparam logic [1:0] STEP_FMTV  = 2'd1;
  localparam logic [1:0] STEP_RET   = 2'd2;
  localparam logic [1:0] STEP_SR    = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_PUSH, ST_FETCH, ST_FIN} seq_state_t;

  typedef struct packed {
    logic [FMT_W-1:0]  fmt;
    logic              extra_en;
    logic [ADDR_W-1:0] extra;
    logic [ADDR_W-1:0] ret;
    logic [SR_W-1:0]   old_sr;
    logic [SR_W-1:0]   entry_sr;
    logic              two_frame;
  } frame_plan_t;

  function automatic logic [SR_W-1:0] entry_sr_f(input logic [SR_W-1:0] sr,
                                                 input logic hw,
                                                 input logic [LVL_W-1:0] lvl);
    logic [SR_W-1:0] s;
    s = sr;
    s[SR_SUP] = 1'b1;
    s[SR_TR_HI:SR_TR_LO] = '0;
    if (hw) s[SR_IM_HI:SR_IM_LO] = lvl;
    return s;
  endfunction

  function automatic logic [SR_W-1:0] fmt_vec_word(input logic [FMT_W-1:0] fmt,
                                                   input logic [IDX_W-1:0] idx);
    return {fmt, 2'b00, idx, 2'b00};
  endfunction

  function automatic logic [ADDR_W-1:0] vec_addr_f(input logic [ADDR_W-1:0] base,
                                                   input logic [IDX_W-1:0] idx);
    return base + {{(ADDR_W-IDX_W-2){1'b0}}, idx, 2'b00};
  endfunction

  function automatic logic in_range(input logic [IDX_W-1:0] v,
                                    input logic [IDX_W-1:0] lo,
                                    input logic [IDX_W-1:0] hi);
    return (v >= lo) && (v <= hi);
  endfunction
endpackage

// File: rtl/efb_classify.sv
module efb_classify
  import efb_pkg::*;
(
  input  logic [IDX_W-1:0]  idx,
  input  logic              hw,
  input  logic [LVL_W-1:0]  lvl,
  input  logic [ADDR_W-1:0] pc,
  input  logic [SR_W-1:0]   sr,
  output frame_plan_t       plan
);
  logic addr_err;
  logic fault_grp;
  logic swtrap;
  logic hw_idx;

  always_comb begin
    addr_err  = (idx == IX_ADDR_ERR);
    fault_grp = (idx == IX_ILLEGAL) || (idx == IX_DIVZ) || (idx == IX_BOUNDS) ||
                (idx == IX_CONDTRAP) || (idx == IX_TRACE);
    swtrap    = !hw && in_range(idx, IX_SWT_LO, IX_SWT_HI);
    hw_idx    = in_range(idx, IX_HW_LO, IX_HW_HI);

    plan.old_sr    = sr;
    plan.entry_sr  = entry_sr_f(sr, hw, lvl);
    plan.extra_en  = addr_err || fault_grp;
    plan.extra     = fault_grp ? pc : '0;
    plan.fmt       = (addr_err || fault_grp) ? 4'd2 : 4'd0;
    plan.ret       = swtrap ? pc + 32'd2 : pc;
    plan.two_frame = hw && sr[SR_MST] && hw_idx && !(addr_err || fault_grp);
  end
endmodule

// File: rtl/efb_seq.sv
module efb_seq
  import efb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  frame_plan_t       plan,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] cur_sp,
  input  logic [ADDR_W-1:0] int_sp,
  input  logic [ADDR_W-1:0] vbr,
  output logic              mem_req,
  output logic              mem_wr,
  output logic              mem_long,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic              busy,
  output logic              push_fire,
  output logic [SR_W-1:0]   new_sr,
  output logic [ADDR_W-1:0] new_pc,
  output logic [ADDR_W-1:0] new_sp,
  output logic [ADDR_W-1:0] msp_out
);
  seq_state_t        state;
  frame_plan_t       pl;
  logic [IDX_W-1:0]  r_idx;
  logic [ADDR_W-1:0] r_isp;
  logic [ADDR_W-1:0] r_vbr;
  logic [ADDR_W-1:0] sp;
  logic [1:0]        step;
  logic              frame2;

  logic              cur_long;
  logic [ADDR_W-1:0] cur_data;
  logic [ADDR_W-1:0] push_addr;
  logic              last_push;
  logic              switch_now;
  logic [ADDR_W-1:0] even_mask;

  assign even_mask = {{(ADDR_W-1){1'b1}}, 1'b0};

  always_comb begin
    cur_long = (step == STEP_EXTRA) || (step == STEP_RET);
    unique case (step)
      STEP_EXTRA: cur_data = pl.extra;
      STEP_FMTV:  cur_data = {{(ADDR_W-SR_W){1'b0}},
                              fmt_vec_word(frame2 ? 4'd1 : pl.fmt, r_idx)};
      STEP_RET:   cur_data = pl.ret;
      default:    cur_data = {{(ADDR_W-SR_W){1'b0}},
                              frame2 ? pl.entry_sr : pl.old_sr};
    endcase
    push_addr  = sp - (cur_long ? 32'd4 : 32'd2);
    push_fire  = (state == ST_PUSH) && mem_ack;
    last_push  = push_fire && (step == STEP_SR);
    switch_now = last_push && pl.two_frame && !frame2;

    mem_req   = (state == ST_PUSH) || (state == ST_FETCH);
    mem_wr    = (state == ST_PUSH);
    mem_long  = (state == ST_FETCH) || cur_long;
    mem_addr  = (state == ST_FETCH) ? vec_addr_f(r_vbr, r_idx) : push_addr;
    mem_wdata = (state == ST_PUSH) ? cur_data : '0;
    done      = (state == ST_FIN);
    busy      = (state != ST_IDLE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      pl      <= '0;
      r_idx   <= '0;
      r_isp   <= '0;
      r_vbr   <= '0;
      sp      <= '0;
      step    <= STEP_FMTV;
      frame2  <= 1'b0;
      new_sr  <= '0;
      new_pc  <= '0;
      new_sp  <= '0;
      msp_out <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            pl     <= plan;
            r_idx  <= idx;
            r_isp  <= int_sp;
            r_vbr  <= vbr;
            sp     <= cur_sp & even_mask;
            step   <= plan.extra_en ? STEP_EXTRA : STEP_FMTV;
            frame2 <= 1'b0;
            state  <= ST_PUSH;
          end
        end
        ST_PUSH: begin
          if (push_fire) begin
            if (switch_now) begin
              msp_out <= push_addr;
              sp      <= r_isp & even_mask;
              frame2  <= 1'b1;
              step    <= STEP_FMTV;
            end else if (last_push) begin
              sp <= push_addr;
              if (!frame2) msp_out <= push_addr;
              state <= ST_FETCH;
            end else begin
              sp   <= push_addr;
              step <= step + 2'd1;
            end
          end
        end
        ST_FETCH: begin
          if (mem_ack) begin
            new_pc <= mem_rdata;
            new_sp <= sp;
            new_sr <= pl.two_frame ? (pl.entry_sr & ~(16'd1 << SR_MST)) : pl.entry_sr;
            state  <= ST_FIN;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exc_frame_builder.sv
module exc_frame_builder
  import efb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDX_W-1:0]  exc_idx,
  input  logic              is_hw,
  input  logic [LVL_W-1:0]  pend_lvl,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [SR_W-1:0]   cur_sr,
  input  logic [ADDR_W-1:0] cur_sp,
  input  logic [ADDR_W-1:0] int_sp,
  input  logic [ADDR_W-1:0] vbr,
  output logic              mem_req,
  output logic              mem_wr,
  output logic              mem_long,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic [SR_W-1:0]   new_sr,
  output logic [ADDR_W-1:0] new_pc,
  output logic [ADDR_W-1:0] new_sp,
  output logic [ADDR_W-1:0] msp_out
);
  frame_plan_t plan;
  logic        seq_busy;
  logic        push_fire;

  efb_classify i_classify (
    .idx  (exc_idx),
    .hw   (is_hw),
    .lvl  (pend_lvl),
    .pc   (cur_pc),
    .sr   (cur_sr),
    .plan (plan)
  );

  efb_seq i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .plan      (plan),
    .idx       (exc_idx),
    .cur_sp    (cur_sp),
    .int_sp    (int_sp),
    .vbr       (vbr),
    .mem_req   (mem_req),
    .mem_wr    (mem_wr),
    .mem_long  (mem_long),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .done      (done),
    .busy      (seq_busy),
    .push_fire (push_fire),
    .new_sr    (new_sr),
    .new_pc    (new_pc),
    .new_sp    (new_sp),
    .msp_out   (msp_out)
  );
endmodule

// File: rtl/efb_checker.sv
module efb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_req,
  input logic        mem_wr,
  input logic        mem_long,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        mem_ack,
  input logic        done,
  input logic [15:0] new_sr,
  input logic        seq_busy,
  input logic        push_fire
);
  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_wr |-> !mem_addr[0]);

  p_word_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_wr && !mem_long |-> mem_wdata[31:16] == 16'h0);

  p_sr_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_sr[13] && (new_sr[15:14] == 2'b00));

  p_read_long_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_wr |-> mem_long);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_wdata)
                             && $stable(mem_wr) && $stable(mem_long));

  p_push_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    push_fire |-> seq_busy && mem_wr);

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind exc_frame_builder efb_checker i_efb_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_wr    (mem_wr),
  .mem_long  (mem_long),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .done      (done),
  .new_sr    (new_sr),
  .seq_busy  (seq_busy),
  .push_fire (push_fire)
);

// File: tb/test_exc_frame_builder.sv
`timescale 1ns/1ps
module test_exc_frame_builder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  exc_idx = '0;
  logic        is_hw = 1'b0;
  logic [2:0]  pend_lvl = '0;
  logic [31:0] cur_pc = '0, cur_sp = '0, int_sp = '0, vbr = '0;
  logic [15:0] cur_sr = '0;
  logic        mem_req, mem_wr, mem_long, mem_ack, done;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, new_pc, new_sp, msp_out;
  logic [15:0] new_sr;

  int checks = 0, fails = 0;
  bit finished = 0;

  // access log filled by the memory responder
  logic [31:0] lg_addr [16];
  logic [31:0] lg_data [16];
  logic        lg_long [16];
  int          lg_n = 0;
  logic [31:0] rd_addr;
  int          rd_n = 0;

  // expected pushes
  logic [31:0] ex_addr [16];
  logic [31:0] ex_data [16];
  logic        ex_long [16];
  int          ex_n;

  always #2.5 clk = ~clk;

  exc_frame_builder i_exc_frame_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .exc_idx(exc_idx), .is_hw(is_hw),
    .pend_lvl(pend_lvl), .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_sp(cur_sp),
    .int_sp(int_sp), .vbr(vbr), .mem_req(mem_req), .mem_wr(mem_wr),
    .mem_long(mem_long), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .new_sr(new_sr),
    .new_pc(new_pc), .new_sp(new_sp), .msp_out(msp_out)
  );

  function automatic logic [31:0] table_word(input logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  // memory responder: 0..2 idle cycles, then one ack per access
  initial begin
    int wait_n;
    mem_ack = 1'b0;
    mem_rdata = '0;
    wait_n = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) begin
        mem_ack = 1'b0;
      end else if (mem_req && rst_n) begin
        if (wait_n == 0) begin
          if (mem_wr) begin
            if (lg_n < 16) begin
              lg_addr[lg_n] = mem_addr;
              lg_data[lg_n] = mem_wdata;
              lg_long[lg_n] = mem_long;
            end
            lg_n++;
          end else begin
            rd_addr = mem_addr;
            rd_n++;
            mem_rdata = table_word(mem_addr);
          end
          mem_ack = 1'b1;
          wait_n = $urandom_range(0, 2);
        end else begin
          wait_n--;
        end
      end
    end
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic add_push(inout logic [31:0] sp, input logic lng, input logic [31:0] d);
    sp = sp - (lng ? 32'd4 : 32'd2);
    ex_addr[ex_n] = sp;
    ex_data[ex_n] = d;
    ex_long[ex_n] = lng;
    ex_n++;
  endtask

  task automatic run_case(input logic [7:0] ix, input logic hw, input logic [2:0] lv,
                          input logic [31:0] pc, input logic [15:0] sr,
                          input logic [31:0] sp, input logic [31:0] isp,
                          input logic [31:0] vb, input bit poke_busy);
    logic [15:0] esr, fsr;
    logic [31:0] ret, s, exp_msp;
    bit          two, f2, swt;
    logic [3:0]  fmt;
    int          guard;
    // model from R1, R4..R7
    esr = sr;
    esr[13] = 1'b1;
    esr[15:14] = 2'b00;
    if (hw) esr[10:8] = lv;
    two = hw && sr[12] && ix >= 24 && ix <= 31;
    f2  = (ix == 3) || (ix == 4) || (ix == 5) || (ix == 6) || (ix == 7) || (ix == 9);
    swt = !hw && ix >= 32 && ix <= 47;
    ret = swt ? pc + 2 : pc;
    fmt = f2 ? 4'd2 : 4'd0;
    fsr = two ? (esr & 16'hEFFF) : esr;
    ex_n = 0;
    s = {sp[31:1], 1'b0};
    if (f2) add_push(s, 1'b1, (ix == 3) ? 32'h0 : pc);
    add_push(s, 1'b0, {16'h0, fmt, 12'h0} + {22'h0, ix, 2'b00});
    add_push(s, 1'b1, ret);
    add_push(s, 1'b0, {16'h0, sr});
    exp_msp = s;
    if (two) begin
      s = {isp[31:1], 1'b0};
      add_push(s, 1'b0, 32'h1000 + {22'h0, ix, 2'b00});
      add_push(s, 1'b1, ret);
      add_push(s, 1'b0, {16'h0, esr});
    end

    @(negedge clk);
    lg_n = 0;
    rd_n = 0;
    exc_idx = ix; is_hw = hw; pend_lvl = lv; cur_pc = pc; cur_sr = sr;
    cur_sp = sp; int_sp = isp; vbr = vb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      // R10: a second start while busy must leave the frame untouched
      @(negedge clk);
      exc_idx = 8'd3; cur_sp = 32'h0000_0100; cur_pc = 32'hDEAD_0000; vbr = 32'h0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!done && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check("R10", "done seen", {31'h0, done}, 32'h1);
    check("R3", "push count", lg_n, ex_n);
    for (int k = 0; k < ex_n && k < lg_n; k++) begin
      check("R2", "push address", lg_addr[k], ex_addr[k]);
      check(two && k >= ex_n - 3 ? "R6" : (f2 ? "R4" : "R3"), "push data",
            lg_data[k], ex_data[k]);
      check("R3", "push size", {31'h0, lg_long[k]}, {31'h0, ex_long[k]});
    end
    check("R8", "one vector read", rd_n, 1);
    check("R8", "vector address", rd_addr, vb + {22'h0, ix, 2'b00});
    check("R8", "new_pc", new_pc, table_word(vb + {22'h0, ix, 2'b00}));
    check("R8", "new_sp", new_sp, s);
    check(two ? "R6" : "R8", "msp_out", msp_out, exp_msp);
    check(two ? "R6" : "R1", "new_sr", {16'h0, new_sr}, {16'h0, fsr});
    @(negedge clk);
    check("R10", "done pulse one cycle", {31'h0, done}, 32'h0);
    check("R10", "results held", new_sp, s);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R10", "reset done low", {31'h0, done}, 32'h0);
    check("R10", "reset req low", {31'h0, mem_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_case(8'd3,  1'b0, 3'd0, 32'h0000_1234, 16'h0000, 32'h0000_8001, 32'h0, 32'h0000_0400, 0); // R2 R4 odd sp
    run_case(8'd5,  1'b0, 3'd0, 32'h00AB_CDE0, 16'hC71F, 32'h0001_0000, 32'h0, 32'h0, 0);         // R4 R1
    run_case(8'd9,  1'b0, 3'd0, 32'h0000_2000, 16'h8000, 32'h0000_3000, 32'h0, 32'h100, 0);       // R4 trace
    run_case(8'd8,  1'b0, 3'd0, 32'h0000_4000, 16'h2700, 32'h0000_5000, 32'h0, 32'h0, 0);         // R5
    run_case(8'd32, 1'b0, 3'd0, 32'h0000_6000, 16'h0004, 32'h0000_7000, 32'h0, 32'h200, 0);       // R7
    run_case(8'd47, 1'b0, 3'd0, 32'hFFFF_FFFE, 16'h0000, 32'h0000_7000, 32'h0, 32'h200, 0);       // R7 wrap
    run_case(8'd47, 1'b1, 3'd4, 32'h0000_6000, 16'h0000, 32'h0000_7000, 32'h0, 32'h200, 0);       // R7 hw: no +2
    run_case(8'd26, 1'b1, 3'd2, 32'h0000_9000, 16'h1700, 32'h0000_A001, 32'h0000_C003, 32'h0, 0); // R6
    run_case(8'd31, 1'b1, 3'd7, 32'h0000_9000, 16'hD000, 32'h0000_A000, 32'h0000_C000, 32'h0, 0); // R6
    run_case(8'd26, 1'b1, 3'd2, 32'h0000_9000, 16'h0700, 32'h0000_A000, 32'h0000_C000, 32'h0, 0); // R5 no master
    run_case(8'd64, 1'b0, 3'd0, 32'h0000_1000, 16'h0000, 32'h0000_2000, 32'h0, 32'h800, 1);       // R10 busy start

    // constrained random
    for (int n = 0; n < 60; n++) begin
      logic [7:0] ix;
      logic hw;
      hw = ($urandom_range(0, 2) == 0);
      if (hw) ix = 8'd24 + 8'($urandom_range(0, 7));
      else ix = ($urandom_range(0, 1) == 0) ? 8'($urandom_range(0, 15)) : 8'($urandom_range(16, 255));
      run_case(ix, hw, 3'($urandom), $urandom, 16'($urandom), $urandom, $urandom,
               $urandom & 32'hFFFF_FFFC, 0);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule